// File: doc/BRIEF.md
# Auto-Incrementing Register Space Engine

This block sits behind an already-decoded serial target interface of a system-management controller. It turns byte-level access requests into reads and writes of a register space with 256 addresses. A burst opens with a start pulse that carries an 8-bit start address. Data bytes then flow in through a write stream or out through a read stream, and a stop pulse closes the burst. Write and read bytes may be mixed in one burst, and both move the same access pointer.

Most of the low address range holds single-byte registers, and the pointer steps past each of them after every byte. A few addresses are fixed multibyte registers. At those addresses the pointer stays put and counts byte positions inside the register. An index/window pair gives access to a 200-byte auxiliary bank. The window advances its own bank index with every byte it moves. Unpopulated addresses read as 0xFF and absorb writes. Read-only values come from the surrounding design through a combinational lookup port (address plus byte position). Every accepted write that lands is reported one cycle later on a strobe with address, byte position and data.

Back-pressure rules: `wr_ready` is high while a burst is open and neither `start_valid` nor `stop` is asserted. A write byte moves on a cycle with `wr_valid && wr_ready`. `rd_valid` is high under the same conditions, but only while `wr_valid` is low. A read byte is consumed on a cycle with `rd_valid && rd_ready`. `rd_data` is valid whenever `rd_valid` is high.

Top module: `regspace_engine`

## Requirements
- R1: A byte moved at a single-byte address (0x00–0x5A, not listed in R2) or at a hole address (R3) advances the pointer by one, wrapping 0xFF to 0x00. A 2-byte read from 0x00 therefore returns registers 0x00 then 0x01.
- R2: At 0x29, 0x2D, 0x4F, 0x7F, 0x60 and 0x61 the pointer address does not change within a burst. Each byte advances a byte position that starts at 0 when the address is entered and saturates at 255.
- R3: Addresses 0x5B–0x5F, 0x62–0x7E and 0x80–0xFF read 0xFF, and writes to them produce no strobe.
- R4: Writing 0x60 sets the bank index to the written value, or to 0 if the value is 200 or more. Reading 0x60 returns the bank index, which always stays below 200.
- R5: Each byte read or written at 0x61 moves the bank entry at the current index. The index then advances by one, wrapping 199 to 0.
- R6: 0x29 is a 5-byte read-write register. 0x4F (6 bytes) and 0x7F (19 bytes) are read-only and supplied by `ext_rdata`. Byte positions past these lengths read 0xFF, and writes there are ignored. Writes to 0x4F and 0x7F are ignored.
- R7: 0x2D is a 100-byte write-only pattern register. Writes to positions 0–99 produce a strobe, and positions 100 and up produce none. All reads return 0x00.
- R8: Single-byte read-only registers 0x08–0x14, 0x3D–0x3E and 0x45–0x4B return `ext_rdata` and ignore writes. Write-only registers 0x20–0x23 and 0x3F read 0x00 and strobe on write. All other single-byte registers store and return written data.
- R9: One cycle after an accepted write that lands, `reg_wr_stb` pulses with the address, the byte position (for 0x61, the bank index before the advance) and the data.
- R10: `wr_ready` and `rd_valid` are low outside a burst and during start or stop cycles. `rd_valid` is low while `wr_valid` is high.
- R11: After reset no burst is open, and all stored registers, the 0x29 bytes, the bank and the bank index are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Opens a burst at `start_addr` |
| start_addr | input | 8 | Start address of the burst |
| stop | input | 1 | Closes the burst |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed |
| rd_data | output | 8 | Read byte |
| reg_wr_stb | output | 1 | Write landed (registered) |
| reg_wr_addr | output | 8 | Address of the landed write |
| reg_wr_idx | output | 8 | Byte position or bank index of the landed write |
| reg_wr_data | output | 8 | Data of the landed write |
| ext_raddr | output | 8 | Current address for the read-only lookup |
| ext_ridx | output | 8 | Current byte position for the read-only lookup |
| ext_rdata | input | 8 | Read-only value for `ext_raddr`/`ext_ridx` |

## Verification
Directed bursts cover the following patterns:
- Plain two-byte reads and writes from 0x00, and a read crossing 0xFF, which separate stepping from holding and test the wrap.
- Over-length bursts into 0x29, 0x2D, 0x4F and 0x7F, which show where filler bytes and dropped strobes begin.
- Index loads just below 199, and loads of 200 or more, which show wrap and clamp behaviour of the bank.

Random bursts at biased start addresses mix reads and writes across class boundaries such as 0x28→0x29 and 0x5A→0x5B. These catch a wrong class decode or a pointer that advances at the wrong address.

// File: rtl/regspace_pkg.sv
package regspace_pkg;

  typedef enum logic [3:0] {
    K_RW, K_RO, K_WO, K_HOLE, K_WIDE_RW, K_PATTERN, K_WIDE_RO, K_INDEX, K_WINDOW
  } kind_e;

  localparam logic [7:0] ADR_WIDE_RW = 8'h29;
  localparam logic [7:0] ADR_PATTERN = 8'h2D;
  localparam logic [7:0] ADR_RO_A    = 8'h4F;
  localparam logic [7:0] ADR_RO_B    = 8'h7F;
  localparam logic [7:0] ADR_INDEX   = 8'h60;
  localparam logic [7:0] ADR_WINDOW  = 8'h61;

  localparam logic [7:0] RO0_LO = 8'h08, RO0_HI = 8'h14;
  localparam logic [7:0] RO1_LO = 8'h3D, RO1_HI = 8'h3E;
  localparam logic [7:0] RO2_LO = 8'h45, RO2_HI = 8'h4B;
  localparam logic [7:0] WO0_LO = 8'h20, WO0_HI = 8'h23;
  localparam logic [7:0] WO1    = 8'h3F;

  function automatic logic is_fixed(kind_e k);
    return (k == K_WIDE_RW) || (k == K_PATTERN) || (k == K_WIDE_RO) ||
           (k == K_INDEX)   || (k == K_WINDOW);
  endfunction

endpackage

// File: rtl/regspace_decode.sv
module regspace_decode import regspace_pkg::*; #(
  parameter int POOL_TOP    = 8'h5A,
  parameter int WIDE_RW_LEN = 5,
  parameter int PAT_LEN     = 100,
  parameter int RO_A_LEN    = 6,
  parameter int RO_B_LEN    = 19
) (
  input  logic [7:0] addr,
  input  logic [7:0] idx,
  output kind_e      kind,
  output logic       in_len
);
  localparam logic [7:0] TOP_B  = 8'(POOL_TOP);
  localparam logic [7:0] WRW_B  = 8'(WIDE_RW_LEN);
  localparam logic [7:0] PAT_B  = 8'(PAT_LEN);
  localparam logic [7:0] ROA_B  = 8'(RO_A_LEN);
  localparam logic [7:0] ROB_B  = 8'(RO_B_LEN);

  always_comb begin
    if (addr == ADR_WIDE_RW)                         kind = K_WIDE_RW;
    else if (addr == ADR_PATTERN)                    kind = K_PATTERN;
    else if (addr == ADR_RO_A || addr == ADR_RO_B)   kind = K_WIDE_RO;
    else if (addr == ADR_INDEX)                      kind = K_INDEX;
    else if (addr == ADR_WINDOW)                     kind = K_WINDOW;
    else if (addr > TOP_B)                           kind = K_HOLE;
    else if ((addr >= RO0_LO && addr <= RO0_HI) ||
             (addr >= RO1_LO && addr <= RO1_HI) ||
             (addr >= RO2_LO && addr <= RO2_HI))     kind = K_RO;
    else if ((addr >= WO0_LO && addr <= WO0_HI) ||
             addr == WO1)                            kind = K_WO;
    else                                             kind = K_RW;
  end

  always_comb begin
    case (kind)
      K_WIDE_RW: in_len = idx < WRW_B;
      K_PATTERN: in_len = idx < PAT_B;
      K_WIDE_RO: in_len = (addr == ADR_RO_A) ? (idx < ROA_B) : (idx < ROB_B);
      default:   in_len = 1'b1;
    endcase
  end
endmodule

// File: rtl/regspace_pool.sv
module regspace_pool #(
  parameter int POOL_TOP = 8'h5A,
  parameter int WIDE_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pool_we,
  input  logic       wide_we,
  input  logic [7:0] addr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] pool_rdata,
  output logic [7:0] wide_rdata
);
  localparam int POOL_N = POOL_TOP + 1;
  localparam int PW     = $clog2(POOL_N);
  localparam int WW     = $clog2(WIDE_LEN);
  localparam logic [7:0] TOP_B = 8'(POOL_TOP);
  localparam logic [7:0] WL_B  = 8'(WIDE_LEN);

  logic [7:0] mem  [POOL_N];
  logic [7:0] wide [WIDE_LEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < POOL_N; i++)   mem[i]  <= '0;
      for (int i = 0; i < WIDE_LEN; i++) wide[i] <= '0;
    end else begin
      if (pool_we && addr <= TOP_B) mem[addr[PW-1:0]] <= wdata;
      if (wide_we && idx < WL_B)    wide[idx[WW-1:0]] <= wdata;
    end
  end

  assign pool_rdata = (addr <= TOP_B) ? mem[addr[PW-1:0]] : 8'h00;
  assign wide_rdata = (idx < WL_B) ? wide[idx[WW-1:0]] : 8'hFF;
endmodule

// File: rtl/regspace_aux.sv
module regspace_aux #(
  parameter int DEPTH = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic [7:0] idx_wdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  input  logic       adv,
  output logic [7:0] idx,
  output logic [7:0] rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] DEPTH_B = 8'(DEPTH);
  localparam logic [7:0] LAST_B  = 8'(DEPTH - 1);

  logic [7:0] bank [DEPTH];
  logic [7:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      idx_q <= '0;
    end else begin
      if (idx_we) idx_q <= (idx_wdata >= DEPTH_B) ? 8'h00 : idx_wdata;
      if (dat_we) bank[idx_q[AW-1:0]] <= dat_wdata;
      if (adv)    idx_q <= (idx_q == LAST_B) ? 8'h00 : idx_q + 8'd1;
    end
  end

  assign idx   = idx_q;
  assign rdata = bank[idx_q[AW-1:0]];
endmodule

// File: rtl/regspace_engine.sv
module regspace_engine import regspace_pkg::*; #(
  parameter int POOL_TOP    = 8'h5A,
  parameter int WIDE_RW_LEN = 5,
  parameter int PAT_LEN     = 100,
  parameter int RO_A_LEN    = 6,
  parameter int RO_B_LEN    = 19,
  parameter int AUX_DEPTH   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  input  logic [7:0] start_addr,
  input  logic       stop,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       reg_wr_stb,
  output logic [7:0] reg_wr_addr,
  output logic [7:0] reg_wr_idx,
  output logic [7:0] reg_wr_data,
  output logic [7:0] ext_raddr,
  output logic [7:0] ext_ridx,
  input  logic [7:0] ext_rdata
);
  logic       open_q;
  logic [7:0] cur_q, bidx_q;
  kind_e      kind;
  logic       in_len, fixed;
  logic       wr_fire, rd_fire, fire, land;
  logic [7:0] pool_rdata, wide_rdata, aux_idx, aux_rdata;

  regspace_decode #(
    .POOL_TOP(POOL_TOP), .WIDE_RW_LEN(WIDE_RW_LEN), .PAT_LEN(PAT_LEN),
    .RO_A_LEN(RO_A_LEN), .RO_B_LEN(RO_B_LEN)
  ) u_dec (.addr(cur_q), .idx(bidx_q), .kind(kind), .in_len(in_len));

  assign fixed    = is_fixed(kind);
  assign wr_ready = open_q && !start_valid && !stop;
  assign rd_valid = open_q && !start_valid && !stop && !wr_valid;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign fire     = wr_fire || rd_fire;

  // pointer sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cur_q  <= '0;
      bidx_q <= '0;
    end else if (start_valid) begin
      open_q <= 1'b1;
      cur_q  <= start_addr;
      bidx_q <= '0;
    end else if (stop) begin
      open_q <= 1'b0;
    end else if (fire) begin
      if (fixed) begin
        bidx_q <= (bidx_q == 8'hFF) ? 8'hFF : bidx_q + 8'd1;
      end else begin
        cur_q  <= cur_q + 8'd1;
        bidx_q <= '0;
      end
    end
  end

  regspace_pool #(.POOL_TOP(POOL_TOP), .WIDE_LEN(WIDE_RW_LEN)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pool_we(wr_fire && kind == K_RW),
    .wide_we(wr_fire && kind == K_WIDE_RW && in_len),
    .addr(cur_q), .idx(bidx_q), .wdata(wr_data),
    .pool_rdata(pool_rdata), .wide_rdata(wide_rdata)
  );

  regspace_aux #(.DEPTH(AUX_DEPTH)) u_aux (
    .clk(clk), .rst_n(rst_n),
    .idx_we(wr_fire && kind == K_INDEX), .idx_wdata(wr_data),
    .dat_we(wr_fire && kind == K_WINDOW), .dat_wdata(wr_data),
    .adv(fire && kind == K_WINDOW),
    .idx(aux_idx), .rdata(aux_rdata)
  );

  assign ext_raddr = cur_q;
  assign ext_ridx  = bidx_q;

  always_comb begin
    case (kind)
      K_RW:      rd_data = pool_rdata;
      K_RO:      rd_data = ext_rdata;
      K_WIDE_RW: rd_data = wide_rdata;
      K_WIDE_RO: rd_data = in_len ? ext_rdata : 8'hFF;
      K_INDEX:   rd_data = aux_idx;
      K_WINDOW:  rd_data = aux_rdata;
      K_HOLE:    rd_data = 8'hFF;
      default:   rd_data = 8'h00;
    endcase
  end

  // write strobe toward functional registers
  always_comb begin
    case (kind)
      K_RW, K_WO, K_WINDOW: land = wr_fire;
      K_WIDE_RW, K_PATTERN: land = wr_fire && in_len;
      default:              land = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_wr_stb  <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_idx  <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_stb <= land;
      if (land) begin
        reg_wr_addr <= cur_q;
        reg_wr_idx  <= (kind == K_WINDOW) ? aux_idx : bidx_q;
        reg_wr_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/regspace_checker.sv
module regspace_checker import regspace_pkg::*; #(
  parameter int AUX_DEPTH = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       open_q,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       wr_fire,
  input logic       rd_fire,
  input kind_e      kind,
  input logic [7:0] cur,
  input logic [7:0] aux_idx,
  input logic [7:0] rd_data,
  input logic       reg_wr_stb
);
  localparam logic [7:0] LAST_B  = 8'(AUX_DEPTH - 1);
  localparam logic [7:0] DEPTH_B = 8'(AUX_DEPTH);

  assert_single_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || rd_fire) && !is_fixed(kind) |=> cur == $past(cur) + 8'd1);

  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || rd_fire) && is_fixed(kind) |=> $stable(cur));

  assert_hole_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && kind == K_HOLE |-> rd_data == 8'hFF);

  assert_hole_nostb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && kind == K_HOLE |=> !reg_wr_stb);

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_idx < DEPTH_B);

  assert_window_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire || rd_fire) && kind == K_WINDOW |=>
      aux_idx == (($past(aux_idx) == LAST_B) ? 8'h00 : $past(aux_idx) + 8'd1));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !wr_ready && !rd_valid);

  assert_wr_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_valid);
endmodule

bind regspace_engine regspace_checker #(.AUX_DEPTH(AUX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .open_q(open_q), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .wr_fire(wr_fire),
  .rd_fire(rd_fire), .kind(kind), .cur(cur_q), .aux_idx(aux_idx),
  .rd_data(rd_data), .reg_wr_stb(reg_wr_stb)
);

// File: tb/tb_regspace_engine.sv
module tb_regspace_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, stop = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] start_addr = '0, wr_data = '0;
  logic wr_ready, rd_valid, reg_wr_stb;
  logic [7:0] rd_data, reg_wr_addr, reg_wr_idx, reg_wr_data, ext_raddr, ext_ridx, ext_rdata;

  always #5 clk = ~clk;

  function automatic logic [7:0] ext_val(logic [7:0] a, logic [7:0] i);
    return a ^ {i[4:0], 3'b000} ^ 8'h3C;
  endfunction
  assign ext_rdata = ext_val(ext_raddr, ext_ridx);

  regspace_engine dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .stop(stop), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .ext_raddr(ext_raddr), .ext_ridx(ext_ridx),
    .ext_rdata(ext_rdata)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] pool_m [256];
  logic [7:0] wide_m [5];
  logic [7:0] bank_m [200];
  int idx_m = 0;
  logic [7:0] cur_m = 0;
  int bidx_m = 0;

  // 0 rw,1 ro,2 wo,3 hole,4 wide rw,5 pattern,6 wide ro,7 index,8 window
  function automatic int kind_m(logic [7:0] a);
    if (a == 8'h29) return 4;
    if (a == 8'h2D) return 5;
    if (a == 8'h4F || a == 8'h7F) return 6;
    if (a == 8'h60) return 7;
    if (a == 8'h61) return 8;
    if (a > 8'h5A) return 3;
    if ((a >= 8'h08 && a <= 8'h14) || a == 8'h3D || a == 8'h3E ||
        (a >= 8'h45 && a <= 8'h4B)) return 1;
    if ((a >= 8'h20 && a <= 8'h23) || a == 8'h3F) return 2;
    return 0;
  endfunction

  function automatic string req_of(int k);
    case (k)
      3: return "R3";
      4, 6: return "R6";
      5: return "R7";
      7: return "R4";
      8: return "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a, int i);
    int len;
    len = (a == 8'h4F) ? 6 : 19;
    case (kind_m(a))
      0: return pool_m[a];
      1: return ext_val(a, 8'(i));
      3: return 8'hFF;
      4: return (i < 5) ? wide_m[i] : 8'hFF;
      6: return (i < len) ? ext_val(a, 8'(i)) : 8'hFF;
      7: return 8'(idx_m);
      8: return bank_m[idx_m];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic advance_m(input int k);
    if (k == 8) idx_m = (idx_m == 199) ? 0 : idx_m + 1;
    if (k >= 4) bidx_m = (bidx_m == 255) ? 255 : bidx_m + 1;
    else begin cur_m = cur_m + 8'd1; bidx_m = 0; end
  endtask

  task automatic t_start(input logic [7:0] a);
    start_valid = 1; start_addr = a;
    @(posedge clk); @(negedge clk);
    start_valid = 0; cur_m = a; bidx_m = 0;
  endtask

  task automatic t_stop();
    stop = 1;
    @(posedge clk); @(negedge clk);
    stop = 0;
  endtask

  task automatic t_write(input logic [7:0] d);
    int k; bit estb; logic [7:0] ea; int ei; string rq;
    k = kind_m(cur_m); ea = cur_m; ei = bidx_m; estb = 0; rq = req_of(k);
    case (k)
      0: begin pool_m[cur_m] = d; estb = 1; end
      2: estb = 1;
      4: if (bidx_m < 5) begin wide_m[bidx_m] = d; estb = 1; end
      5: estb = (bidx_m < 100);
      7: idx_m = (d >= 8'd200) ? 0 : int'(d);
      8: begin bank_m[idx_m] = d; ei = idx_m; estb = 1; end
      default: ;
    endcase
    advance_m(k);
    wr_valid = 1; wr_data = d;
    #1 check(wr_ready == 1'b1, "R10", "wr_ready in burst", wr_ready, 1);
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    check(reg_wr_stb == estb, rq, "R9 strobe", reg_wr_stb, estb);
    if (estb) begin
      check(reg_wr_addr == ea, "R9", "strobe addr", reg_wr_addr, ea);
      check(reg_wr_idx == 8'(ei), "R9", "strobe idx", reg_wr_idx, ei);
      check(reg_wr_data == d, "R9", "strobe data", reg_wr_data, d);
    end
  endtask

  task automatic t_read(input string lab);
    int k; logic [7:0] e; string rq;
    k = kind_m(cur_m); e = exp_rd(cur_m, bidx_m);
    rq = (lab == "") ? req_of(k) : lab;
    rd_ready = 1;
    #1 check(rd_valid == 1'b1, "R10", "rd_valid in burst", rd_valid, 1);
    check(rd_data == e, rq, "read data", rd_data, e);
    @(posedge clk); @(negedge clk);
    rd_ready = 0;
    advance_m(k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) pool_m[i] = 0;
    for (int i = 0; i < 5; i++) wide_m[i] = 0;
    for (int i = 0; i < 200; i++) bank_m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R11 / R10: idle after reset
    check(wr_ready == 0, "R11", "wr_ready idle", wr_ready, 0);
    check(rd_valid == 0, "R10", "rd_valid idle", rd_valid, 0);
    check(reg_wr_stb == 0, "R11", "strobe idle", reg_wr_stb, 0);
    t_start(8'h00); t_read("R11"); t_stop();
    t_start(8'h61); t_read("R11"); t_stop();
    t_start(8'h29); t_read("R11"); t_stop();
    // R1: stepping and wrap
    t_start(8'h00); t_write(8'hA1); t_write(8'hB2); t_stop();
    t_start(8'h00); t_read("R1"); t_read("R1"); t_stop();
    t_start(8'hFE); t_read("R1"); t_read("R1"); t_read("R1"); t_stop();
    // R2 / R6: 0x29 held, over-length
    t_start(8'h29);
    for (int i = 0; i < 6; i++) t_write(8'h10 + 8'(i));
    t_stop();
    t_start(8'h29);
    for (int i = 0; i < 7; i++) t_read("R2");
    t_stop();
    // R3: hole
    t_start(8'h5B); t_write(8'h55); t_stop();
    t_start(8'h5B); t_read("R3"); t_read("R3"); t_stop();
    // R4 / R5: bank wrap and clamp
    t_start(8'h60); t_write(8'd198); t_stop();
    t_start(8'h61); t_write(8'hC1); t_write(8'hC2); t_write(8'hC3); t_stop();
    t_start(8'h60); t_read("R4"); t_stop();
    t_start(8'h60); t_write(8'd198); t_stop();
    t_start(8'h61); t_read("R5"); t_read("R5"); t_read("R5"); t_stop();
    t_start(8'h60); t_write(8'd250); t_read("R4"); t_stop();
    // R7: pattern over-length
    t_start(8'h2D);
    for (int i = 0; i < 102; i++) t_write(8'(i * 3));
    t_stop();
    t_start(8'h2D); t_read("R7"); t_read("R7"); t_stop();
    // R6: read-only wide
    t_start(8'h4F); t_write(8'h99);
    for (int i = 0; i < 8; i++) t_read("R6");
    t_stop();
    t_start(8'h7F);
    for (int i = 0; i < 21; i++) t_read("R6");
    t_stop();
    // R8: ro and wo single
    t_start(8'h08); t_write(8'h77); t_stop();
    t_start(8'h08); t_read("R8"); t_stop();
    t_start(8'h20); t_write(8'h66); t_stop();
    t_start(8'h20); t_read("R8"); t_stop();
    // random bursts
    for (int b = 0; b < 500; b++) begin
      logic [7:0] a;
      int sel, len;
      logic [7:0] hot [6];
      hot = '{8'h29, 8'h2D, 8'h4F, 8'h7F, 8'h60, 8'h61};
      sel = int'($urandom % 4);
      case (sel)
        0: a = 8'($urandom);
        1: a = hot[$urandom % 6];
        2: a = 8'($urandom % 91);
        default: a = 8'h56 + 8'($urandom % 8);
      endcase
      t_start(a);
      len = 1 + int'($urandom % 8);
      for (int j = 0; j < len; j++) begin
        if ($urandom % 2 == 0) t_write(8'($urandom));
        else t_read("");
      end
      t_stop();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule